// File: doc/BRIEF.md
# DDR2 Posted Column Command Latency Scheduler

This block sits on the device side of a DDR2-style memory and turns the command stream seen at the pins into internally timed column events. Mode-register-set commands are decoded into four registers, chosen by the low two bank-address bits. From these registers the block keeps a CAS latency, an additive latency and a high-temperature refresh-rate flag. Malformed or unsafe settings raise a sticky error flag.

Each accepted READ or WRITE may arrive before the row-to-column delay has elapsed. The block holds it for the additive latency and then issues it to the internal column path. It then emits a read-data-valid pulse at the read latency (additive plus CAS) for reads, and a write-data-accept pulse one clock earlier for writes. Each pulse carries the bank and column of its own command. Every command records the latency settings in force when it was accepted, so a later mode change does not disturb commands already in flight.

Top module: `ddr2_col_sched`

## Requirements
- R1: After reset, CAS latency is 3, additive latency is 0, `hitemp_o` and `err_o` are 0, and no strobe is high.
- R2: On `cmd_i`=1 (mode set), `ba_i[1:0]` selects the register. With 0, CAS latency is taken from `addr_i[6:4]`. With 1, additive latency is taken from `addr_i[5:3]`. With 2, the temperature register is written. With 3, nothing visible changes.
- R3: An additive-latency code of 5, 6 or 7 sets `err_o` and leaves the previous additive latency in force.
- R4: A CAS-latency code outside 3..6 sets `err_o` and leaves the previous CAS latency in force.
- R5: A READ (`cmd_i`=3) or WRITE (`cmd_i`=4) accepted at rising edge E gives a one-cycle `col_vld_o` pulse that starts at edge E+1+AL. The pulse carries the command's bank, column and direction (`col_wr_o`=1 for a write).
- R6: A READ accepted at edge E gives a one-cycle `rd_vld_o` pulse that starts at edge E+1+AL+CL, with its bank and column.
- R7: A WRITE accepted at edge E gives a one-cycle `wr_acc_o` pulse that starts at edge E+AL+CL, one clock before the read latency, with its bank and column.
- R8: A new column command may be accepted on every clock, and all pulses come out in acceptance order.
- R9: A mode-set command changes the latencies only of column commands accepted after it. Commands already in flight keep their own timing.
- R10: Writing a legal additive latency that is greater than the parameter `TRCD_MIN` applies the value and sets `err_o`.
- R11: A write to register 2 copies `addr_i[7]` to `hitemp_o`. Any other non-zero `addr_i` bit in that write sets `err_o`, and bit 7 is still applied.
- R12: If two in-flight commands reach the same strobe in the same cycle, the earlier-accepted one is emitted and `err_o` is set at the next edge.
- R13: Once set, `err_o` stays high until reset. NOP (`cmd_i`=0) and ACTIVATE (`cmd_i`=2) leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 mode set, 2 activate, 3 read, 4 write |
| ba_i | input | 3 | Bank address |
| addr_i | input | 14 | Address bus (mode value or column) |
| col_vld_o | output | 1 | Internal column command pulse |
| col_wr_o | output | 1 | Column command is a write |
| col_ba_o | output | 3 | Bank of the column command |
| col_addr_o | output | 14 | Column of the column command |
| rd_vld_o | output | 1 | Read-data-valid pulse |
| rd_ba_o | output | 3 | Bank of the read pulse |
| rd_addr_o | output | 14 | Column of the read pulse |
| wr_acc_o | output | 1 | Write-data-accept pulse |
| wr_ba_o | output | 3 | Bank of the write pulse |
| wr_addr_o | output | 14 | Column of the write pulse |
| hitemp_o | output | 1 | High-temperature refresh-rate enable |
| err_o | output | 1 | Sticky configuration/collision error |

## Verification
Column commands are sent under the reset latencies and under a raised CAS and additive latency. Sending them as a dense mix of reads and writes on consecutive clocks separates correct per-direction latency from an off-by-one between the read and write paths. A mode change between two reads separates per-command latency capture from a shared global setting. A deliberately staggered pair that lands on the same clock exposes the priority and error logic. Reserved codes, the unused fourth register and the temperature bit are each followed by a timed command or an output check, so that "kept" can be told apart from "applied".

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;
    localparam int BA_W    = 3;
    localparam int ADDR_W  = 14;
    localparam int AL_W    = 3;
    localparam int CL_W    = 3;
    localparam int AL_MAX  = 4;
    localparam int CL_MIN  = 3;
    localparam int CL_MAX  = 6;
    localparam int RL_W    = 4;
    localparam int DEPTH   = AL_MAX + CL_MAX + 1;
    localparam int CL_LSB  = 4;
    localparam int AL_LSB  = 3;
    localparam int HT_BIT  = 7;
    localparam int N_KIND  = 3;

    localparam logic [2:0] CMD_NOP = 3'd0;
    localparam logic [2:0] CMD_MRS = 3'd1;
    localparam logic [2:0] CMD_ACT = 3'd2;
    localparam logic [2:0] CMD_RD  = 3'd3;
    localparam logic [2:0] CMD_WR  = 3'd4;

    localparam int KIND_COL = 0;
    localparam int KIND_RD  = 1;
    localparam int KIND_WR  = 2;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] col;
        logic [AL_W-1:0]   al;
        logic [RL_W-1:0]   rl;
    } slot_t;
endpackage

// File: rtl/ddr2_mode_regs.sv
module ddr2_mode_regs
    import ddr2_sched_pkg::*;
#(
    parameter int TRCD_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [1:0]        sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CL_W-1:0]   cl_o,
    output logic [AL_W-1:0]   al_o,
    output logic              hitemp_o,
    output logic              bad_wr_o
);
    typedef struct packed {
        logic [CL_W-1:0] cl;
        logic [AL_W-1:0] al;
        logic            ht;
    } mode_t;

    localparam logic [ADDR_W-1:0] HT_MASK = ADDR_W'(1) << HT_BIT;

    mode_t             m_d, m_q;
    logic              bad_d;
    logic [CL_W-1:0]   cl_f;
    logic [AL_W-1:0]   al_f;

    assign cl_f = addr_i[CL_LSB +: CL_W];
    assign al_f = addr_i[AL_LSB +: AL_W];

    always_comb begin
        m_d   = m_q;
        bad_d = 1'b0;
        if (cmd_i == CMD_MRS) begin
            case (sel_i)
                2'd0: begin
                    if (cl_f >= CL_W'(CL_MIN) && cl_f <= CL_W'(CL_MAX))
                        m_d.cl = cl_f;
                    else
                        bad_d = 1'b1;
                end
                2'd1: begin
                    if (al_f <= AL_W'(AL_MAX)) begin
                        m_d.al = al_f;
                        if (int'(al_f) > TRCD_MIN)
                            bad_d = 1'b1;
                    end else begin
                        bad_d = 1'b1;
                    end
                end
                2'd2: begin
                    m_d.ht = addr_i[HT_BIT];
                    if ((addr_i & ~HT_MASK) != '0)
                        bad_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.cl <= CL_W'(CL_MIN);
            m_q.al <= '0;
            m_q.ht <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign cl_o     = m_q.cl;
    assign al_o     = m_q.al;
    assign hitemp_o = m_q.ht;
    assign bad_wr_o = bad_d;

    a_r4_cl_range: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.cl >= CL_W'(CL_MIN)) && (m_q.cl <= CL_W'(CL_MAX)));

    a_r3_al_range: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.al <= AL_W'(AL_MAX));

    a_r3_al_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MRS && sel_i == 2'd1 && al_f > AL_W'(AL_MAX)) |=> $stable(m_q.al));

    a_r4_cl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MRS && sel_i == 2'd0 && (cl_f < CL_W'(CL_MIN) || cl_f > CL_W'(CL_MAX)))
        |=> $stable(m_q.cl));
endmodule

// File: rtl/ddr2_lat_pipe.sv
module ddr2_lat_pipe
    import ddr2_sched_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              cmd_i,
    input  logic [BA_W-1:0]         ba_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [AL_W-1:0]         al_i,
    input  logic [CL_W-1:0]         cl_i,
    output slot_t [DEPTH-1:0]       stg_o
);
    typedef struct packed {
        slot_t [DEPTH-1:0] stg;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        p_d.stg[0].vld = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
        p_d.stg[0].wr  = (cmd_i == CMD_WR);
        p_d.stg[0].ba  = ba_i;
        p_d.stg[0].col = addr_i;
        p_d.stg[0].al  = al_i;
        p_d.stg[0].rl  = RL_W'(al_i) + RL_W'(cl_i);
        for (int k = 1; k < DEPTH; k++)
            p_d.stg[k] = p_q.stg[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign stg_o = p_q.stg;

    a_r8_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RD || cmd_i == CMD_WR) |=> (p_q.stg[0].vld && p_q.stg[0].col == $past(addr_i)));
endmodule

// File: rtl/ddr2_stage_pick.sv
module ddr2_stage_pick
    import ddr2_sched_pkg::*;
#(
    parameter int KIND = KIND_COL
) (
    input  slot_t [DEPTH-1:0]  stg_i,
    output logic               vld_o,
    output logic               wr_o,
    output logic [BA_W-1:0]    ba_o,
    output logic [ADDR_W-1:0]  col_o,
    output logic               multi_o
);
    logic [DEPTH-1:0] hit;

    for (genvar k = 0; k < DEPTH; k++) begin : g_hit
        if (KIND == KIND_COL) begin : g_col
            assign hit[k] = stg_i[k].vld && (RL_W'(stg_i[k].al) == RL_W'(k));
        end else if (KIND == KIND_RD) begin : g_rd
            assign hit[k] = stg_i[k].vld && !stg_i[k].wr && (stg_i[k].rl == RL_W'(k));
        end else begin : g_wr
            assign hit[k] = stg_i[k].vld && stg_i[k].wr && (stg_i[k].rl == RL_W'(k + 1));
        end
    end

    always_comb begin
        vld_o = 1'b0;
        wr_o  = 1'b0;
        ba_o  = '0;
        col_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (hit[k]) begin
                vld_o = 1'b1;
                wr_o  = stg_i[k].wr;
                ba_o  = stg_i[k].ba;
                col_o = stg_i[k].col;
            end
        end
    end

    assign multi_o = ($countones(hit) > 1);
endmodule

// File: rtl/ddr2_col_sched.sv
module ddr2_col_sched
    import ddr2_sched_pkg::*;
#(
    parameter int TRCD_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              col_vld_o,
    output logic              col_wr_o,
    output logic [BA_W-1:0]   col_ba_o,
    output logic [ADDR_W-1:0] col_addr_o,
    output logic              rd_vld_o,
    output logic [BA_W-1:0]   rd_ba_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_acc_o,
    output logic [BA_W-1:0]   wr_ba_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              hitemp_o,
    output logic              err_o
);
    typedef struct packed {
        logic err;
    } top_t;

    logic [CL_W-1:0]   cl_w;
    logic [AL_W-1:0]   al_w;
    logic              bad_wr;
    slot_t [DEPTH-1:0] stg;

    logic              pk_vld   [N_KIND];
    logic              pk_wr    [N_KIND];
    logic [BA_W-1:0]   pk_ba    [N_KIND];
    logic [ADDR_W-1:0] pk_col   [N_KIND];
    logic [N_KIND-1:0] pk_multi;

    top_t t_d, t_q;

    ddr2_mode_regs #(.TRCD_MIN(TRCD_MIN)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_i),
        .sel_i    (ba_i[1:0]),
        .addr_i   (addr_i),
        .cl_o     (cl_w),
        .al_o     (al_w),
        .hitemp_o (hitemp_o),
        .bad_wr_o (bad_wr)
    );

    ddr2_lat_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .ba_i   (ba_i),
        .addr_i (addr_i),
        .al_i   (al_w),
        .cl_i   (cl_w),
        .stg_o  (stg)
    );

    for (genvar g = 0; g < N_KIND; g++) begin : g_pick
        ddr2_stage_pick #(.KIND(g)) u_pick (
            .stg_i   (stg),
            .vld_o   (pk_vld[g]),
            .wr_o    (pk_wr[g]),
            .ba_o    (pk_ba[g]),
            .col_o   (pk_col[g]),
            .multi_o (pk_multi[g])
        );
    end

    always_comb begin
        t_d     = t_q;
        t_d.err = t_q.err | bad_wr | (|pk_multi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign col_vld_o  = pk_vld[KIND_COL];
    assign col_wr_o   = pk_wr[KIND_COL];
    assign col_ba_o   = pk_ba[KIND_COL];
    assign col_addr_o = pk_col[KIND_COL];
    assign rd_vld_o   = pk_vld[KIND_RD];
    assign rd_ba_o    = pk_ba[KIND_RD];
    assign rd_addr_o  = pk_col[KIND_RD];
    assign wr_acc_o   = pk_vld[KIND_WR];
    assign wr_ba_o    = pk_ba[KIND_WR];
    assign wr_addr_o  = pk_col[KIND_WR];
    assign err_o      = t_q.err;

    a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r12_collide_err: assert property (@(posedge clk) disable iff (!rst_n)
        (|pk_multi) |=> err_o);

    a_r10_trcd_err: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(al_w) > TRCD_MIN) |-> err_o);

    a_r7_wr_dir: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc_o |-> pk_wr[KIND_WR]);
endmodule

// File: tb/sim_ddr2_col_sched.sv
module sim_ddr2_col_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = 3'd0;
    logic [2:0]  ba_i = 3'd0;
    logic [13:0] addr_i = 14'd0;
    logic        col_vld_o, col_wr_o, rd_vld_o, wr_acc_o, hitemp_o, err_o;
    logic [2:0]  col_ba_o, rd_ba_o, wr_ba_o;
    logic [13:0] col_addr_o, rd_addr_o, wr_addr_o;

    ddr2_col_sched u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ba_i(ba_i), .addr_i(addr_i),
        .col_vld_o(col_vld_o), .col_wr_o(col_wr_o), .col_ba_o(col_ba_o), .col_addr_o(col_addr_o),
        .rd_vld_o(rd_vld_o), .rd_ba_o(rd_ba_o), .rd_addr_o(rd_addr_o),
        .wr_acc_o(wr_acc_o), .wr_ba_o(wr_ba_o), .wr_addr_o(wr_addr_o),
        .hitemp_o(hitemp_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          t;
        bit          wr;
        logic [2:0]  ba;
        logic [13:0] col;
        string       req;
    } exp_t;

    exp_t colq[$];
    exp_t rdq[$];
    exp_t wrq[$];

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int mal = 0;
    int mcl = 3;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_i = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mal = 0;
        mcl = 3;
    endtask

    task automatic drive(input logic [2:0] c, input logic [2:0] b, input logic [13:0] a);
        cmd_i  = c;
        ba_i   = b;
        addr_i = a;
        @(negedge clk);
        cmd_i  = 3'd0;
    endtask

    task automatic mrs(input logic [1:0] sel, input logic [13:0] a);
        if (sel == 2'd0 && a[6:4] >= 3 && a[6:4] <= 6) mcl = int'(a[6:4]);
        if (sel == 2'd1 && a[5:3] <= 4) mal = int'(a[5:3]);
        drive(3'd1, {1'b0, sel}, a);
    endtask

    task automatic colcmd(input bit wr, input logic [2:0] b, input logic [13:0] c,
                          input bit track, input string req);
        exp_t e;
        e.wr = wr; e.ba = b; e.col = c; e.req = req;
        if (track) begin
            e.t = cyc + 1 + mal;
            colq.push_back(e);
            if (wr) begin
                e.t = cyc + mal + mcl;
                wrq.push_back(e);
            end else begin
                e.t = cyc + 1 + mal + mcl;
                rdq.push_back(e);
            end
        end
        drive(wr ? 3'd4 : 3'd3, b, c);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mon(input string name, input bit v, input bit wr, input logic [2:0] b,
                       input logic [13:0] c, ref exp_t q[$]);
        exp_t e;
        if (q.size() > 0 && q[0].t < cyc) begin
            e = q.pop_front();
            chk(1'b0, e.req, {name, " pulse missing at cycle"}, cyc, e.t);
        end
        if (v) begin
            if (q.size() == 0) begin
                chk(1'b0, "R5", {name, " unexpected pulse"}, 1, 0);
            end else begin
                e = q.pop_front();
                chk(e.t == cyc, e.req, {name, " pulse cycle"}, cyc, e.t);
                chk(e.ba == b && e.col == c, e.req, {name, " bank/column"}, int'({b, c}), int'({e.ba, e.col}));
                chk(e.wr == wr, e.req, {name, " direction"}, int'(wr), int'(e.wr));
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            mon("col", col_vld_o, col_wr_o, col_ba_o, col_addr_o, colq);
            mon("rd", rd_vld_o, 1'b0, rd_ba_o, rd_addr_o, rdq);
            mon("wr", wr_acc_o, 1'b1, wr_ba_o, wr_addr_o, wrq);
        end
    end

    bit done = 1'b0;

    task automatic finish_run();
        chk(colq.size() == 0 && rdq.size() == 0 && wrq.size() == 0, "R8",
            "outstanding expected pulses", colq.size() + rdq.size() + wrq.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int p;
        do_reset();
        // R1: reset state
        chk(err_o == 0, "R1", "err after reset", err_o, 0);
        chk(hitemp_o == 0, "R1", "hitemp after reset", hitemp_o, 0);
        chk(!col_vld_o && !rd_vld_o && !wr_acc_o, "R1", "strobes after reset",
            int'({col_vld_o, rd_vld_o, wr_acc_o}), 0);
        // R1/R5/R6/R7: default latencies AL0 CL3
        colcmd(1'b0, 3'd1, 14'h0011, 1'b1, "R6");
        colcmd(1'b1, 3'd2, 14'h0022, 1'b1, "R7");
        idle(14);

        // R2: raise CL to 5 and AL to 2, then a dense mix (R8)
        mrs(2'd0, 14'(5 << 4));
        mrs(2'd1, 14'(2 << 3));
        // R13: activate and NOP produce nothing
        drive(3'd2, 3'd3, 14'h3fff);
        drive(3'd0, 3'd0, 14'h0000);
        for (int i = 0; i < 8; i++)
            colcmd(i[0], 3'(i), 14'(16'h0100 + i * 7), 1'b1, "R8");
        idle(16);
        chk(err_o == 0, "R2", "err after legal settings", err_o, 0);

        // R2: fourth register write changes nothing visible
        drive(3'd1, 3'd3, 14'h3fff);
        colcmd(1'b0, 3'd4, 14'h0abc, 1'b1, "R2");
        idle(14);
        chk(err_o == 0 && hitemp_o == 0, "R2", "fourth register write effect",
            int'({err_o, hitemp_o}), 0);

        // R3: reserved additive code keeps AL=2
        mrs(2'd1, 14'(6 << 3));
        chk(err_o == 1, "R3", "err after reserved AL", err_o, 1);
        colcmd(1'b1, 3'd5, 14'h0155, 1'b1, "R3");
        idle(14);
        chk(err_o == 1, "R13", "err sticky", err_o, 1);

        // R4: reserved CAS code keeps CL
        do_reset();
        mrs(2'd0, 14'(7 << 4));
        chk(err_o == 1, "R4", "err after reserved CL", err_o, 1);
        colcmd(1'b0, 3'd6, 14'h0066, 1'b1, "R4");
        idle(12);

        // R11: temperature bit and reserved bits
        do_reset();
        mrs(2'd2, 14'h0080);
        chk(hitemp_o == 1, "R11", "hitemp set", hitemp_o, 1);
        chk(err_o == 0, "R11", "no err on clean write", err_o, 0);
        mrs(2'd2, 14'h0000);
        chk(hitemp_o == 0, "R11", "hitemp cleared", hitemp_o, 0);
        mrs(2'd2, 14'h0084);
        chk(hitemp_o == 1, "R11", "hitemp applied with reserved bit", hitemp_o, 1);
        chk(err_o == 1, "R11", "err on reserved bit", err_o, 1);

        // R10: AL at the limit is clean, above it errors but applies
        do_reset();
        mrs(2'd1, 14'(3 << 3));
        chk(err_o == 0, "R10", "AL equal to tRCD", err_o, 0);
        mrs(2'd1, 14'(4 << 3));
        chk(err_o == 1, "R10", "AL above tRCD", err_o, 1);
        colcmd(1'b0, 3'd7, 14'h0777, 1'b1, "R10");
        idle(14);

        // R9: mode set between two reads
        do_reset();
        colcmd(1'b0, 3'd1, 14'h0201, 1'b1, "R9");
        mrs(2'd1, 14'(2 << 3));
        colcmd(1'b0, 3'd2, 14'h0202, 1'b1, "R9");
        idle(14);
        chk(err_o == 0, "R9", "no err for ordered change", err_o, 0);

        // R12: two commands meet at the same stage
        do_reset();
        mrs(2'd1, 14'(3 << 3));
        p = cyc;
        colcmd(1'b0, 3'd3, 14'h0303, 1'b1, "R12");
        mrs(2'd1, 14'(1 << 3));
        colcmd(1'b0, 3'd4, 14'h0404, 1'b0, "R12");
        while (cyc < p + 4) @(negedge clk);
        chk(err_o == 0, "R12", "err before collision edge", err_o, 0);
        @(negedge clk);
        chk(err_o == 1, "R12", "err after collision", err_o, 1);
        idle(12);

        done = 1'b1;
        finish_run();
    end
endmodule